// File: doc/BRIEF.md
# Bidirectional Logical Shift Unit

This block is the logical shifter of a DSP-style execution datapath. It accepts either a 32-bit data word or a 40-bit accumulator value and moves it left or right by a requested number of places. Vacated bit positions are always filled with zeros. There is no sign extension, no rotation and no saturation. The result keeps the width of the selected operand. A zero-result flag comes with every result. The input operand is only read, and the shifted value is produced on a separate output.

Two amount conventions are supported, and a mode input selects between them. In compound-assignment mode, a separate direction bit picks left or right, and the whole 32-bit amount is treated as an unsigned count. In this mode the operand is always 32 bits wide. In signed-amount mode, the amount is a two's-complement number: its sign selects the direction and its magnitude gives the distance. In this mode the operand may be a data word or an accumulator. In both modes, an amount outside the legal range clears the result instead of wrapping. The amount port does not care whether the count came from an immediate field or from a register. By default, a parameter places a registered output stage with a valid bit after the shifter.

Top module: `lsh_unit`

## Requirements
- R1: In signed-amount mode (`mode`=1), an amount from +1 to +31 shifts the operand left by that many places, and zeros enter at bit 0.
- R2: In signed-amount mode, an amount from -1 to -32 shifts the operand right by its magnitude. Zeros enter at the top bit of the selected width, which is bit 39 for an accumulator.
- R3: In signed-amount mode, an amount above +31 or below -32 gives an all-zero result. At -32, a 32-bit operand gives zero, and a 40-bit operand gives its bits 39:32 in result bits 7:0.
- R4: In signed-amount mode, `is_acc`=1 selects a 40-bit operand. `is_acc`=0 selects `operand[31:0]`: bits 39:32 of the operand are ignored, and bits 39:32 of the result are zero.
- R5: In compound-assignment mode (`mode`=0), `dir_right`=1 shifts right and `dir_right`=0 shifts left by the unsigned 32-bit amount. The operand width is 32 bits whatever the value of `is_acc`.
- R6: In compound-assignment mode, every amount greater than 31 gives a result of zero, including amounts whose only set bits are above bit 4.
- R7: An amount of zero returns the operand at its selected width unchanged, in both modes.
- R8: `zero` is 1 exactly when every bit of `result` is 0.
- R9: With the output register enabled, `result`, `zero` and `out_valid` reflect an operation one clock after `in_valid` is presented. `out_valid` is 0 in any cycle after a cycle without `in_valid`, and `result`, `zero` and `out_valid` are all 0 after reset (`rst` is synchronous and active high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| mode | input | 1 | 0 = direction bit with unsigned amount, 1 = signed amount |
| is_acc | input | 1 | 1 = 40-bit accumulator operand (signed mode only) |
| dir_right | input | 1 | Direction in mode 0: 1 = right, 0 = left |
| amount | input | 32 | Shift amount, either unsigned or two's complement depending on mode |
| operand | input | 40 | Value to shift; only bits 31:0 are used for a 32-bit operand |
| out_valid | output | 1 | Result valid |
| result | output | 40 | Shifted value, zero above the selected width |
| zero | output | 1 | Result is all zero |

## Verification
The assertions check on every cycle that the zero flag agrees with the result, that a valid input is followed by a valid output, and that the result holds when nothing new is presented. They also check that a 32-bit result never carries upper bits, that a zero amount passes the masked operand through, and that a right shift never leaves a one in the top bit at the selected width. The bench scenarios have to show the actual distances and directions. They also cover the range limits at +31, -32, 32 and values with only high bits set, the accumulator high-byte case, and the fact that `is_acc` is ignored in compound-assignment mode.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
   typedef enum logic {
      MODE_CMPD   = 1'b0,
      MODE_SIGNED = 1'b1
   } lsh_mode_e;
endpackage

// File: rtl/lsh_amount_decode.sv
module lsh_amount_decode #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 32,
   parameter int MAG_W  = 6
) (
   input  logic             mode_signed,
   input  logic             dir_right,
   input  logic [AMT_W-1:0] amount,
   output logic             go_right,
   output logic [MAG_W-1:0] mag,
   output logic             kill
);
   localparam logic [AMT_W-1:0] MAX_LEFT  = AMT_W'(DATA_W - 1);
   localparam logic [AMT_W-1:0] MAX_RIGHT = AMT_W'(DATA_W);

   logic             neg;
   logic [AMT_W-1:0] abs_amt;

   always_comb begin
      neg     = amount[AMT_W-1];
      abs_amt = neg ? (~amount + 1'b1) : amount;
      if (mode_signed) begin
         go_right = neg;
         kill     = neg ? (abs_amt > MAX_RIGHT) : (amount > MAX_LEFT);
         mag      = abs_amt[MAG_W-1:0];
      end else begin
         go_right = dir_right;
         kill     = amount > MAX_LEFT;
         mag      = amount[MAG_W-1:0];
      end
   end
endmodule

// File: rtl/lsh_core.sv
module lsh_core #(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 40,
   parameter int MAG_W  = 6
) (
   input  logic [ACC_W-1:0] operand,
   input  logic             wide,
   input  logic             go_right,
   input  logic [MAG_W-1:0] mag,
   input  logic             kill,
   output logic [ACC_W-1:0] res
);
   localparam logic [ACC_W-1:0] NARROW_MASK = {{(ACC_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

   logic [ACC_W-1:0] mask;
   logic [ACC_W-1:0] lft [0:MAG_W];
   logic [ACC_W-1:0] rgt [0:MAG_W];

   assign mask   = wide ? {ACC_W{1'b1}} : NARROW_MASK;
   assign lft[0] = operand & mask;
   assign rgt[0] = operand & mask;

   for (genvar i = 0; i < MAG_W; i++) begin : g_stage
      assign lft[i+1] = mag[i] ? (lft[i] << (2**i)) : lft[i];
      assign rgt[i+1] = mag[i] ? (rgt[i] >> (2**i)) : rgt[i];
   end

   always_comb begin
      if (kill)          res = '0;
      else if (go_right) res = rgt[MAG_W];
      else               res = lft[MAG_W] & mask;
   end

   always_comb begin
      if (go_right && !kill && mag != '0) begin
         AST_RIGHT_TOP_CLEAR: assert (wide ? !res[ACC_W-1] : !res[DATA_W-1]); // R2
      end
   end
endmodule

// File: rtl/lsh_unit.sv
module lsh_unit #(
   parameter int DATA_W  = 32,
   parameter int ACC_W   = 40,
   parameter int AMT_W   = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             mode,
   input  logic             is_acc,
   input  logic             dir_right,
   input  logic [AMT_W-1:0] amount,
   input  logic [ACC_W-1:0] operand,
   output logic             out_valid,
   output logic [ACC_W-1:0] result,
   output logic             zero
);
   import lsh_pkg::*;

   localparam int MAG_W = $clog2(DATA_W) + 1;

   if (ACC_W < DATA_W) begin : g_bad_acc
      $error("ACC_W must be at least DATA_W");
   end
   if (AMT_W < MAG_W + 1) begin : g_bad_amt
      $error("AMT_W too narrow for the shift range");
   end

   lsh_mode_e        mode_e;
   logic             wide;
   logic             go_right;
   logic             kill;
   logic [MAG_W-1:0] mag;
   logic [ACC_W-1:0] shifted;

   assign mode_e = lsh_mode_e'(mode);
   assign wide   = (mode_e == MODE_SIGNED) && is_acc;

   lsh_amount_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W), .MAG_W(MAG_W)) u_dec (
      .mode_signed (mode_e == MODE_SIGNED),
      .dir_right   (dir_right),
      .amount      (amount),
      .go_right    (go_right),
      .mag         (mag),
      .kill        (kill)
   );

   lsh_core #(.DATA_W(DATA_W), .ACC_W(ACC_W), .MAG_W(MAG_W)) u_core (
      .operand  (operand),
      .wide     (wide),
      .go_right (go_right),
      .mag      (mag),
      .kill     (kill),
      .res      (shifted)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            zero      <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result <= shifted;
               zero   <= ~|shifted;
            end
         end
      end

      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid); // R9
      AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> !out_valid); // R9
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> $stable(result)); // R9
      AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> (zero == (result == '0))); // R8
      AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
         (in_valid && !(mode && is_acc)) |=> (result[ACC_W-1:DATA_W] == '0)); // R4
      AST_PASS_ZERO_AMT: assert property (@(posedge clk) disable iff (rst)
         (in_valid && amount == '0) |=>
            (result == $past((mode && is_acc) ? operand
                              : {{(ACC_W-DATA_W){1'b0}}, operand[DATA_W-1:0]}))); // R7
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = shifted;
      assign zero      = ~|shifted;

      always_comb begin
         AST_ZERO_FLAG_C: assert (zero == (result == '0)); // R8
      end
   end
endmodule

// File: tb/tb_lsh_unit.sv
module tb_lsh_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        mode = 1'b0;
   logic        is_acc = 1'b0;
   logic        dir_right = 1'b0;
   logic [31:0] amount = '0;
   logic [39:0] operand = '0;
   logic        out_valid;
   logic [39:0] result;
   logic        zero;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lsh_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .is_acc(is_acc),
      .dir_right(dir_right), .amount(amount), .operand(operand),
      .out_valid(out_valid), .result(result), .zero(zero)
   );

   function automatic logic [39:0] model(input logic m, input logic acc, input logic dr,
                                         input logic [31:0] amt, input logic [39:0] op);
      logic [39:0] msk;
      logic [39:0] v;
      logic [39:0] r;
      longint s;
      msk = (m && acc) ? 40'hFF_FFFF_FFFF : 40'h00_FFFF_FFFF;
      v = op & msk;
      if (!m) begin
         if (amt > 32'd31) r = '0;
         else r = dr ? (v >> amt) : (v << amt);
      end else begin
         s = longint'($signed(amt));
         if (s > 31 || s < -32) r = '0;
         else if (s >= 0) r = v << s;
         else r = v >> (-s);
      end
      return r & msk;
   endfunction

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input string req, input logic m, input logic acc, input logic dr,
                         input logic [31:0] amt, input logic [39:0] op);
      logic [39:0] exp;
      exp = model(m, acc, dr, amt, op);
      @(negedge clk);
      in_valid = 1'b1; mode = m; is_acc = acc; dir_right = dr; amount = amt; operand = op;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, result, exp);
      check({req, " valid"}, {39'd0, out_valid}, 40'd1);
      check("R8", {39'd0, zero}, {39'd0, exp == '0});
   endtask

   task automatic t_reset;
      check("R9 reset valid", {39'd0, out_valid}, 40'd0);
      check("R9 reset result", result, 40'd0);
      check("R9 reset zero", {39'd0, zero}, 40'd0);
   endtask

   task automatic t_signed_left;
      run_op("R1", 1'b1, 1'b0, 1'b0, 32'd1, 40'h00_8000_0001);
      check("R1 value", result, 40'h00_0000_0002);
      run_op("R1", 1'b1, 1'b1, 1'b0, 32'd31, 40'h00_0000_0003);
      check("R1 value", result, 40'h01_8000_0000);
      run_op("R1", 1'b1, 1'b0, 1'b0, 32'd4, 40'hAB_1234_5678);
   endtask

   task automatic t_signed_right;
      run_op("R2", 1'b1, 1'b1, 1'b0, -32'sd4, 40'hF0_0000_0000);
      check("R2 fill", result, 40'h0F_0000_0000);
      run_op("R2", 1'b1, 1'b0, 1'b0, -32'sd1, 40'h00_8000_0000);
      check("R2 value", result, 40'h00_4000_0000);
   endtask

   task automatic t_signed_range;
      run_op("R3", 1'b1, 1'b1, 1'b0, 32'd32, 40'hFF_FFFF_FFFF);
      check("R3 over", result, 40'd0);
      run_op("R3", 1'b1, 1'b1, 1'b0, -32'sd33, 40'hFF_FFFF_FFFF);
      run_op("R3", 1'b1, 1'b0, 1'b0, -32'sd32, 40'h00_FFFF_FFFF);
      check("R3 narrow -32", result, 40'd0);
      run_op("R3", 1'b1, 1'b1, 1'b0, -32'sd32, 40'hA5_1234_5678);
      check("R3 acc -32", result, 40'h00_0000_00A5);
      run_op("R3", 1'b1, 1'b1, 1'b0, 32'h8000_0000, 40'hFF_FFFF_FFFF);
   endtask

   task automatic t_width;
      run_op("R4", 1'b1, 1'b0, 1'b0, 32'd8, 40'hFF_FF00_0001);
      check("R4 narrow", result, 40'h00_0000_0100);
      run_op("R4", 1'b1, 1'b0, 1'b0, -32'sd8, 40'hFF_0000_0000);
      check("R4 ignored upper", result, 40'd0);
   endtask

   task automatic t_compound;
      run_op("R5", 1'b0, 1'b0, 1'b1, 32'd3, 40'h00_8000_0000);
      check("R5 right", result, 40'h00_1000_0000);
      run_op("R5", 1'b0, 1'b0, 1'b0, 32'd3, 40'h00_F000_0001);
      check("R5 left", result, 40'h00_8000_0008);
      run_op("R5", 1'b0, 1'b1, 1'b0, 32'd4, 40'hFF_F000_0001);
      check("R5 acc ignored", result, 40'h00_0000_0010);
   endtask

   task automatic t_compound_big;
      run_op("R6", 1'b0, 1'b0, 1'b0, 32'd32, 40'h00_FFFF_FFFF);
      check("R6 32", result, 40'd0);
      run_op("R6", 1'b0, 1'b0, 1'b1, 32'h0001_0000, 40'h00_FFFF_FFFF);
      check("R6 high bit", result, 40'd0);
      run_op("R6", 1'b0, 1'b0, 1'b1, 32'd31, 40'h00_8000_0000);
      check("R6 edge 31", result, 40'd1);
   endtask

   task automatic t_zero_amount;
      run_op("R7", 1'b1, 1'b1, 1'b0, 32'd0, 40'hC3_DEAD_BEEF);
      check("R7 acc", result, 40'hC3_DEAD_BEEF);
      run_op("R7", 1'b0, 1'b0, 1'b1, 32'd0, 40'hC3_DEAD_BEEF);
      check("R7 cmpd", result, 40'h00_DEAD_BEEF);
   endtask

   task automatic t_zero_flag;
      run_op("R8", 1'b1, 1'b0, 1'b0, 32'd1, 40'h00_8000_0000);
      check("R8 set", {39'd0, zero}, 40'd1);
      run_op("R8", 1'b1, 1'b0, 1'b0, 32'd0, 40'h00_0000_0001);
      check("R8 clear", {39'd0, zero}, 40'd0);
   endtask

   task automatic t_pipeline;
      logic [39:0] held;
      held = result;
      @(negedge clk);
      check("R9 idle valid", {39'd0, out_valid}, 40'd0);
      check("R9 hold", result, held);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_signed_left();
      t_signed_right();
      t_signed_range();
      t_width();
      t_compound();
      t_compound_big();
      t_zero_amount();
      t_zero_flag();
      t_pipeline();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule